// File: doc/BRIEF.md
# Block-Border Position Tracker

This block follows the horizontal position of each luma sample within a row of fixed-width compression blocks. Each pixel occupies two clock cycles. The block counts pixels from the start of each line and works out where the current pixel sits inside its block. It then marks the pixel as lying in the border transition area at a block edge, or in the block interior. A later noise-reduction stage uses this mark to choose between its border gain and its data gain.

The block width and the border width can each be selected. The whole grid can be shifted by a whole number of pixels. With this shift, the border positions still line up with the real block edges when the horizontal timing of the incoming video moves. The controls take effect only at a line start, so no line ever carries a grid that changes partway through. The outputs are registered and arrive one cycle after the sample they describe, together with a delayed copy of the sample-valid input.

Top module: `bbt_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `borderFlag`, `pixPhase` and `validOut` are all 0.
- R2: The sample presented with `lineStart` high has pixel phase 0. The phase then alternates 1, 0, 1, ... on every following cycle until the next `lineStart`. `pixPhase` shows the phase of each sample one cycle after that sample is presented.
- R3: The sample presented with `lineStart` high is at pixel position `blockOffset` within its block, reduced modulo the block width. The position goes up by one after every phase-1 sample.
- R4: When `largeBlock` is 1 the block width is 16 pixels, and when it is 0 the width is 8 pixels. After the last position of a block, the position wraps to 0.
- R5: When `wideBorder` is 0, the border area is 2 pixels: block position 0 and position width-1 are border pixels, and every other position is a data pixel.
- R6: When `wideBorder` is 1, the border area is 4 pixels: positions 0, 1, width-2 and width-1 are border pixels.
- R7: `largeBlock`, `wideBorder` and `blockOffset` are taken in only on a cycle with `lineStart` high. Changing them on any other cycle has no effect on the rest of the line.
- R8: `validOut` equals `sampleValid` delayed by one cycle. `borderFlag` is 1 only when the delayed sample is valid and lies in the border area.
- R9: An offset equal to or larger than the block width wraps. For example, offset 9 with 8-pixel blocks starts the line at position 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock (two cycles per pixel) |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle strobe on the first sample of a line |
| sampleValid | input | 1 | Current sample carries active video |
| largeBlock | input | 1 | 1 selects 16-pixel blocks, 0 selects 8-pixel blocks |
| wideBorder | input | 1 | 1 selects a 4-pixel border, 0 selects a 2-pixel border |
| blockOffset | input | 4 | Grid shift in whole pixels, 0 to 15 |
| borderFlag | output | 1 | Delayed sample is valid and in the border area |
| pixPhase | output | 1 | Phase (0 or 1) of the delayed sample within its pixel |
| validOut | output | 1 | `sampleValid` delayed by one cycle |

## Verification
The bench runs through every combination of block width, border width and offset. Each line is long enough to cross several block edges. The full sweep is run twice. In the first pass the controls stay fixed. This tells apart a wrong wrap point, a wrong border width and a wrong offset reduction, including offsets larger than the block. In the second pass the controls are changed on every cycle after the line start, which exposes any sampling outside `lineStart`. Throughout both passes, `sampleValid` is dropped on a regular pattern of cycles, which shows whether the border mark is gated by validity and whether the output is delayed by exactly one cycle.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
  localparam int OFF_W = 4;

  typedef struct packed {
    logic load;     // line start: preload position
    logic advance;  // second half of a pixel: step position after this cycle
    logic phase;    // phase of the current sample
  } ctrlStrobe_t;

  typedef struct packed {
    logic             largeBlk;
    logic             wideBdr;
    logic [OFF_W-1:0] offset;
  } gridCfg_t;
endpackage

// File: rtl/bbt_ctrl.sv
module bbt_ctrl
  import bbt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic             largeBlock,
  input  logic             wideBorder,
  input  logic [OFF_W-1:0] blockOffset,
  output ctrlStrobe_t      strb,
  output gridCfg_t         activeCfg
);
  logic     phaseQ;
  gridCfg_t cfgQ;
  gridCfg_t cfgIn;
  logic     curPhase;

  assign cfgIn = '{largeBlk: largeBlock, wideBdr: wideBorder, offset: blockOffset};

  // At line start the incoming controls are used at once; otherwise the held copy.
  assign activeCfg = lineStart ? cfgIn : cfgQ;
  assign curPhase  = lineStart ? 1'b0 : phaseQ;

  assign strb.load    = lineStart;
  assign strb.phase   = curPhase;
  assign strb.advance = curPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= 1'b0;
      cfgQ   <= '0;
    end else begin
      phaseQ <= ~curPhase;
      if (lineStart) cfgQ <= cfgIn;
    end
  end

  // R2: a line always begins on phase 0
  a_r2_start_phase0: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |-> !strb.phase);
  // R2: phase alternates between line starts
  a_r2_alt_hi: assert property (@(posedge clk) disable iff (!rstN)
    strb.phase |=> (lineStart || !strb.phase));
  a_r2_alt_lo: assert property (@(posedge clk) disable iff (!rstN)
    !strb.phase |=> (lineStart || strb.phase));
  // R7: held controls change only after a line start
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> $stable(cfgQ));
endmodule

// File: rtl/bbt_datapath.sv
module bbt_datapath
  import bbt_pkg::*;
#(
  parameter int SMALL_BLK  = 8,   // power of two
  parameter int LARGE_BLK  = 16,  // power of two, >= SMALL_BLK
  parameter int NARROW_BDR = 2,   // even
  parameter int WIDE_BDR   = 4    // even
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  gridCfg_t    cfg,
  input  logic        validIn,
  output logic        borderFlag,
  output logic        pixPhase,
  output logic        validOut
);
  localparam int POS_W = $clog2(LARGE_BLK);
  localparam int CW    = (POS_W > OFF_W) ? POS_W : OFF_W;
  localparam int SW    = POS_W + 1;

  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] curPos;
  logic [POS_W-1:0] loadPos;
  logic [POS_W-1:0] incPos;
  logic [CW-1:0]    sizeMask;
  logic [SW-1:0]    sizeV;
  logic [SW-1:0]    halfV;
  logic             inBorder;

  assign sizeMask = cfg.largeBlk ? CW'(LARGE_BLK - 1) : CW'(SMALL_BLK - 1);
  assign sizeV    = cfg.largeBlk ? SW'(LARGE_BLK) : SW'(SMALL_BLK);
  assign halfV    = cfg.wideBdr ? SW'(WIDE_BDR / 2) : SW'(NARROW_BDR / 2);

  // Offset reduced modulo block width by masking (widths are powers of two)
  assign loadPos = POS_W'(CW'(cfg.offset) & sizeMask);
  assign curPos  = strb.load ? loadPos : posQ;
  assign incPos  = POS_W'((CW'(curPos) + CW'(1)) & sizeMask);

  // Border straddles the edge: half of it at each end of a block
  assign inBorder = ({1'b0, curPos} < halfV) || ({1'b0, curPos} >= (sizeV - halfV));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ       <= '0;
      borderFlag <= 1'b0;
      pixPhase   <= 1'b0;
      validOut   <= 1'b0;
    end else begin
      posQ       <= strb.advance ? incPos : curPos;
      borderFlag <= validIn & inBorder;
      pixPhase   <= strb.phase;
      validOut   <= validIn;
    end
  end

  // R4: position always lies inside the selected block width
  a_r4_pos_in_range: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, curPos} < sizeV);
  // R3: position holds across the first half of a pixel
  a_r3_hold_first_half: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.load) |=> $stable(posQ));
  // R8: border mark never appears on an invalid sample
  a_r8_flag_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    borderFlag |-> validOut);
endmodule

// File: rtl/bbt_top.sv
module bbt_top
  import bbt_pkg::*;
#(
  parameter int SMALL_BLK  = 8,
  parameter int LARGE_BLK  = 16,
  parameter int NARROW_BDR = 2,
  parameter int WIDE_BDR   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic             sampleValid,
  input  logic             largeBlock,
  input  logic             wideBorder,
  input  logic [OFF_W-1:0] blockOffset,
  output logic             borderFlag,
  output logic             pixPhase,
  output logic             validOut
);
  ctrlStrobe_t strb;
  gridCfg_t    activeCfg;

  bbt_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .lineStart   (lineStart),
    .largeBlock  (largeBlock),
    .wideBorder  (wideBorder),
    .blockOffset (blockOffset),
    .strb        (strb),
    .activeCfg   (activeCfg)
  );

  bbt_datapath #(
    .SMALL_BLK  (SMALL_BLK),
    .LARGE_BLK  (LARGE_BLK),
    .NARROW_BDR (NARROW_BDR),
    .WIDE_BDR   (WIDE_BDR)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfg        (activeCfg),
    .validIn    (sampleValid),
    .borderFlag (borderFlag),
    .pixPhase   (pixPhase),
    .validOut   (validOut)
  );

  // R1: outputs are quiet on the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!borderFlag && !pixPhase && !validOut));
endmodule

// File: tb/bbt_top_tb_top.sv
module bbt_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStart = 1'b0;
  logic       sampleValid = 1'b0;
  logic       largeBlock = 1'b0;
  logic       wideBorder = 1'b0;
  logic [3:0] blockOffset = 4'd0;
  logic       borderFlag, pixPhase, validOut;

  int nVec = 0;
  int nBad = 0;

  always #10 clk = ~clk;  // 50 MHz

  bbt_top dut_i (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .sampleValid(sampleValid),
    .largeBlock(largeBlock), .wideBorder(wideBorder), .blockOffset(blockOffset),
    .borderFlag(borderFlag), .pixPhase(pixPhase), .validOut(validOut)
  );

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // One line of LEN cycles; controls held (R3 R4 R5 R6 R9) or disturbed after start (R7)
  task automatic runLine(input int lg, input int wd, input int off, input int disturb);
    int size = lg ? 16 : 8;
    int half = wd ? 2 : 1;
    for (int k = 0; k < 44; k++) begin
      int n, pos, vld, bdr;
      string tag;
      @(negedge clk);
      lineStart   = (k == 0);
      vld         = ((k % 7) != 5) ? 1 : 0;
      sampleValid = vld[0];
      if (k == 0 || disturb == 0) begin
        largeBlock  = lg[0];
        wideBorder  = wd[0];
        blockOffset = off[3:0];
      end else begin
        largeBlock  = ~lg[0] ^ k[0];
        wideBorder  = ~wd[0];
        blockOffset = 4'((off + k * 3) & 15);
      end
      @(posedge clk);
      #1;
      n   = k / 2;
      pos = (off + n) % size;  // R3 R4 R9
      bdr = (pos < half || pos >= size - half) ? 1 : 0;
      if (disturb != 0)      tag = "R7";
      else if (off >= size)  tag = "R9";
      else if (wd != 0)      tag = "R6";
      else                   tag = "R5";
      checkBit(tag, "borderFlag", borderFlag, logic'(vld & bdr));
      checkBit("R2", "pixPhase", pixPhase, logic'(k % 2));
      checkBit("R8", "validOut", validOut, logic'(vld));
    end
  endtask

  initial begin
    sampleValid = 1'b1;
    lineStart   = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs held low under reset
    checkBit("R1", "borderFlag", borderFlag, 1'b0);
    checkBit("R1", "pixPhase", pixPhase, 1'b0);
    checkBit("R1", "validOut", validOut, 1'b0);
    @(negedge clk);
    rstN        = 1'b1;
    lineStart   = 1'b0;
    sampleValid = 1'b0;
    @(posedge clk);
    #1;
    checkBit("R1", "validOut", validOut, 1'b0);
    for (int d = 0; d < 2; d++)
      for (int lg = 0; lg < 2; lg++)
        for (int wd = 0; wd < 2; wd++)
          for (int off = 0; off < 16; off++)
            runLine(lg, wd, off, d);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule